// File: doc/BRIEF.md
# Delay-Line Calibration Sequencer

This block calibrates a tapped-delay-line time-to-digital converter and then builds the lookup table that maps raw fine codes to calibrated fine time. Calibration starts by itself when reset is released. The block first zeroes an external histogram memory. It then counts incoming pulses into the bin that each pulse's raw fine code selects, until a fixed total number of hits has been gathered. This is a code-density measurement: a bin that collects more hits belongs to a wider delay tap.

Once the histogram is complete, the block asks an external frequency counter for the ring-oscillator frequency twice. The first reading is kept as the reference and the second as the current value. The block then walks the bins in ascending order. For each entry it accumulates the widths of the bins below it, scales that sum by reference/current with an internal restoring divider, and writes the result into an external lookup memory. Ready rises after the last entry has been written and stays high until the next reset. Both memories return read data one cycle after the address is presented. The frequency counter answers each start pulse with a done pulse that carries its value.

Top module: `tdc_cal_ctrl`

## Requirements
- R1: In the NBINS cycles that begin with the first cycle after reset is released, the block writes zero to histogram addresses 0, 1, ..., NBINS-1, one per cycle in ascending order, where NBINS = 2^RAW_W. With no command, it then starts collecting pulses.
- R2: Each accepted pulse adds one to the bin addressed by `pulse_raw`. The block drives that address in the accepting cycle, waits one cycle for the read data, and writes read data + 1 to the same address in the following cycle.
- R3: A pulse that arrives in the two cycles after an accepted pulse is ignored, and so is any pulse that arrives after collection has finished. Neither changes any histogram bin.
- R4: Collection stops after exactly 2^FP_W accepted pulses, and only then is the first `freq_start` issued.
- R5: `freq_start` is a single-cycle pulse and is issued exactly twice. The value that comes with the first `freq_done` is the reference f0, and the value that comes with the second is the current frequency f. While `freq_done` is low, the block waits and issues no lookup-table write.
- R6: Entry i of the lookup table equals floor(f0 × (sum of bins 1 through i-1) / f). Entries 0 and 1 are zero, and bin 0 never contributes to any entry.
- R7: Each lookup address 0 through NBINS-1 is written exactly once, in ascending order.
- R8: `ready` rises in the cycle after the last lookup write and stays high until reset. While `ready` is high, the block makes no memory write and issues no frequency request.
- R9: With an even histogram (2^(FP_W-RAW_W) hits in every bin), f0 = 1 and f = 2, entry i equals (i-1) × 2^(FP_W-RAW_W) / 2 for i from 1 to NBINS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pulse_valid | input | 1 | A time stamp is present this cycle |
| pulse_raw | input | RAW_W | Raw fine code of the pulse |
| hist_addr | output | RAW_W | Histogram memory address |
| hist_we | output | 1 | Histogram memory write enable |
| hist_wdata | output | FP_W+1 | Histogram memory write data |
| hist_rdata | input | FP_W+1 | Histogram read data, valid one cycle after the address |
| freq_start | output | 1 | Request a ring-oscillator frequency reading |
| freq_done | input | 1 | Reading complete, `freq_value` valid |
| freq_value | input | FREQ_W | Ring-oscillator frequency reading |
| lut_addr | output | RAW_W | Lookup memory address |
| lut_we | output | 1 | Lookup memory write enable |
| lut_wdata | output | FP_W+1+FREQ_W | Calibrated fine time for `lut_addr` |
| ready | output | 1 | Lookup table complete |

## Verification
On every cycle the assertions check that each increment writes back the value read two cycles earlier plus one to the same address, that frequency requests are single pulses limited to two and that the first comes only after the full hit count, that lookup writes climb one address at a time, that entries 0 and 1 are zero, and that ready stays high and quiet. Only the bench's scenarios can show the arithmetic: the final bin counts after pulses that were ignored, each scaled cumulative entry for uniform, skewed and large-ratio histograms, and the one-cycle gap between the last write and ready.

// File: rtl/tdc_cal_pkg.sv
// Shared state encodings for the delay-line calibration sequencer.
package tdc_cal_pkg;

    // Top-level phase of the calibration run.
    typedef enum logic [2:0] {
        T_HIST,
        T_F0_REQ,
        T_F0_WAIT,
        T_F_REQ,
        T_F_WAIT,
        T_LUT,
        T_READY
    } top_st_e;

    // Histogram engine: clear, wait for a pulse, read-modify-write, finished.
    typedef enum logic [2:0] {
        H_CLEAR,
        H_COLLECT,
        H_WAIT,
        H_WRITE,
        H_DONE
    } hist_st_e;

    // Lookup builder: read bin, capture and divide, write entry.
    typedef enum logic [2:0] {
        L_IDLE,
        L_RD,
        L_CAP,
        L_DIV,
        L_WR,
        L_DONE
    } lut_st_e;

endpackage

// File: rtl/tdc_cal_div.sv
// Restoring unsigned divider, one quotient bit per cycle.
// Assumes NW >= 2. A start pulse loads the operands. After NW step cycles,
// done pulses for one cycle and quot then holds until the next start.
// A zero divisor gives an all-ones quotient.
module tdc_cal_div #(
    parameter int NW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [NW-1:0] quot,
    output logic          done
);
    localparam int CW = $clog2(NW + 1);

    logic [NW-1:0] qr;
    logic [DW-1:0] rem;
    logic [DW-1:0] den_q;
    logic [CW-1:0] cnt;
    logic [DW:0]   trial;
    logic          ge;

    // Trial subtraction for the current step.
    always_comb begin
        trial = {rem, qr[NW-1]};
        ge    = trial >= {1'b0, den_q};
    end

    // Operand load, shift-subtract iteration and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qr    <= '0;
            rem   <= '0;
            den_q <= '0;
            cnt   <= '0;
            done  <= 1'b0;
        end else if (start) begin
            qr    <= num;
            rem   <= '0;
            den_q <= den;
            cnt   <= CW'(NW);
            done  <= 1'b0;
        end else if (cnt != '0) begin
            rem  <= ge ? DW'(trial - {1'b0, den_q}) : trial[DW-1:0];
            qr   <= {qr[NW-2:0], ge};
            cnt  <= cnt - 1'b1;
            done <= (cnt == CW'(1));
        end else begin
            done <= 1'b0;
        end
    end

    assign quot = qr;
endmodule

// File: rtl/tdc_cal_hist.sv
// Code-density histogram engine.
// After reset it zeroes every bin, one per cycle. It then accepts a pulse
// only while idle, and increments its bin by read, wait, write. It stops
// after 2^FP_W accepted hits. Assumes the memory returns read data one cycle
// after the address.
module tdc_cal_hist
    import tdc_cal_pkg::*;
#(
    parameter int RAW_W = 4,
    parameter int FP_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_valid,
    input  logic [RAW_W-1:0] pulse_raw,
    input  logic [FP_W:0]    hist_rdata,
    output logic [RAW_W-1:0] hist_addr,
    output logic             hist_we,
    output logic [FP_W:0]    hist_wdata,
    output logic             done
);
    localparam int NBINS = 1 << RAW_W;
    localparam int TOTAL = 1 << FP_W;

    hist_st_e         state;
    logic [RAW_W-1:0] clr_idx;
    logic [RAW_W-1:0] raw_q;
    logic [FP_W:0]    bin_q;
    logic [FP_W:0]    hit_cnt;

    // Phase sequencing, operand capture and hit counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= H_CLEAR;
            clr_idx <= '0;
            raw_q   <= '0;
            bin_q   <= '0;
            hit_cnt <= '0;
        end else begin
            case (state)
                H_CLEAR: begin
                    clr_idx <= clr_idx + 1'b1;
                    if (clr_idx == RAW_W'(NBINS - 1)) state <= H_COLLECT;
                end
                H_COLLECT: begin
                    if (pulse_valid) begin
                        raw_q <= pulse_raw;
                        state <= H_WAIT;
                    end
                end
                H_WAIT: begin
                    bin_q <= hist_rdata;
                    state <= H_WRITE;
                end
                H_WRITE: begin
                    hit_cnt <= hit_cnt + 1'b1;
                    state   <= (hit_cnt == (FP_W+1)'(TOTAL - 1)) ? H_DONE : H_COLLECT;
                end
                default: state <= H_DONE;
            endcase
        end
    end

    // Memory port drive for the current phase.
    always_comb begin
        hist_we    = 1'b0;
        hist_wdata = '0;
        hist_addr  = raw_q;
        case (state)
            H_CLEAR: begin
                hist_we   = 1'b1;
                hist_addr = clr_idx;
            end
            H_COLLECT: hist_addr = pulse_raw;
            H_WRITE: begin
                hist_we    = 1'b1;
                hist_wdata = bin_q + 1'b1;
            end
            default: ;
        endcase
    end

    assign done = (state == H_DONE);
endmodule

// File: rtl/tdc_cal_lut.sv
// Cumulative lookup-table builder.
// On start it walks bins 0..NBINS-1. Each entry gets floor(f0*acc/f), where
// acc is the sum of bins 1..i-1, and then bin i is added to acc (bin 0 never
// is). f0 and f must be stable from start until done.
module tdc_cal_lut
    import tdc_cal_pkg::*;
#(
    parameter int RAW_W  = 4,
    parameter int FP_W   = 8,
    parameter int FREQ_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [FREQ_W-1:0]       f0,
    input  logic [FREQ_W-1:0]       f,
    input  logic [FP_W:0]           hist_rdata,
    output logic [RAW_W-1:0]        hist_addr,
    output logic [RAW_W-1:0]        lut_addr,
    output logic                    lut_we,
    output logic [FP_W+FREQ_W:0]    lut_wdata,
    output logic                    done
);
    localparam int NBINS = 1 << RAW_W;
    localparam int ACC_W = FP_W + 1;
    localparam int LUT_W = ACC_W + FREQ_W;

    lut_st_e          state;
    logic [RAW_W-1:0] idx;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] bin_q;
    logic [LUT_W-1:0] div_num;
    logic [LUT_W-1:0] div_quot;
    logic             div_start;
    logic             div_done;
    logic             last;

    assign last      = (idx == RAW_W'(NBINS - 1));
    assign div_start = (state == L_CAP);
    assign div_num   = LUT_W'(acc) * LUT_W'(f0);

    tdc_cal_div #(.NW(LUT_W), .DW(FREQ_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (f),
        .quot  (div_quot),
        .done  (div_done)
    );

    // Entry sequencing and running sum of bin widths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= L_IDLE;
            idx   <= '0;
            acc   <= '0;
            bin_q <= '0;
        end else begin
            case (state)
                L_IDLE: if (start) state <= L_RD;
                L_RD:   state <= L_CAP;
                L_CAP: begin
                    bin_q <= hist_rdata;
                    state <= L_DIV;
                end
                L_DIV:  if (div_done) state <= L_WR;
                L_WR: begin
                    if (idx != '0) acc <= acc + bin_q;
                    idx   <= idx + 1'b1;
                    state <= last ? L_DONE : L_RD;
                end
                default: state <= L_DONE;
            endcase
        end
    end

    assign hist_addr = idx;
    assign lut_addr  = idx;
    assign lut_we    = (state == L_WR);
    assign lut_wdata = div_quot;
    assign done      = (state == L_WR) && last;
endmodule

// File: rtl/tdc_cal_ctrl.sv
// Delay-line calibration sequencer, top level.
// Runs histogram collection, two frequency readings (reference, then
// current) and the lookup build, and then holds ready. It owns the
// histogram port in the collection phase and lends its read side to the
// lookup builder afterwards. Assumes freq_done pulses once per request.
module tdc_cal_ctrl
    import tdc_cal_pkg::*;
#(
    parameter int RAW_W  = 4,
    parameter int FP_W   = 8,
    parameter int FREQ_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pulse_valid,
    input  logic [RAW_W-1:0]     pulse_raw,
    output logic [RAW_W-1:0]     hist_addr,
    output logic                 hist_we,
    output logic [FP_W:0]        hist_wdata,
    input  logic [FP_W:0]        hist_rdata,
    output logic                 freq_start,
    input  logic                 freq_done,
    input  logic [FREQ_W-1:0]    freq_value,
    output logic [RAW_W-1:0]     lut_addr,
    output logic                 lut_we,
    output logic [FP_W+FREQ_W:0] lut_wdata,
    output logic                 ready
);
    top_st_e           state;
    logic [FREQ_W-1:0] f0_q;
    logic [FREQ_W-1:0] f_q;
    logic              lut_start;
    logic              lut_done;
    logic              hist_done;
    logic [RAW_W-1:0]  h_addr;
    logic              h_we;
    logic [FP_W:0]     h_wdata;
    logic [RAW_W-1:0]  l_haddr;

    tdc_cal_hist #(.RAW_W(RAW_W), .FP_W(FP_W)) u_hist (
        .clk         (clk),
        .rst_n       (rst_n),
        .pulse_valid (pulse_valid),
        .pulse_raw   (pulse_raw),
        .hist_rdata  (hist_rdata),
        .hist_addr   (h_addr),
        .hist_we     (h_we),
        .hist_wdata  (h_wdata),
        .done        (hist_done)
    );

    assign lut_start = (state == T_F_WAIT) && freq_done;

    tdc_cal_lut #(.RAW_W(RAW_W), .FP_W(FP_W), .FREQ_W(FREQ_W)) u_lut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (lut_start),
        .f0         (f0_q),
        .f          (f_q),
        .hist_rdata (hist_rdata),
        .hist_addr  (l_haddr),
        .lut_addr   (lut_addr),
        .lut_we     (lut_we),
        .lut_wdata  (lut_wdata),
        .done       (lut_done)
    );

    // Phase sequencing and capture of the two frequency readings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= T_HIST;
            f0_q  <= '0;
            f_q   <= '0;
        end else begin
            case (state)
                T_HIST:    if (hist_done) state <= T_F0_REQ;
                T_F0_REQ:  state <= T_F0_WAIT;
                T_F0_WAIT: if (freq_done) begin
                    f0_q  <= freq_value;
                    state <= T_F_REQ;
                end
                T_F_REQ:   state <= T_F_WAIT;
                T_F_WAIT:  if (freq_done) begin
                    f_q   <= freq_value;
                    state <= T_LUT;
                end
                T_LUT:     if (lut_done) state <= T_READY;
                default:   state <= T_READY;
            endcase
        end
    end

    // Histogram port ownership: collector first, then lookup reads only.
    always_comb begin
        if (state == T_HIST) begin
            hist_addr  = h_addr;
            hist_we    = h_we;
            hist_wdata = h_wdata;
        end else begin
            hist_addr  = l_haddr;
            hist_we    = 1'b0;
            hist_wdata = '0;
        end
    end

    assign freq_start = (state == T_F0_REQ) || (state == T_F_REQ);
    assign ready      = (state == T_READY);
endmodule

// File: rtl/tdc_cal_ctrl_chk.sv
// Property checker for the calibration sequencer, bound to every instance.
// It watches the ports only and keeps small counters of its own.
module tdc_cal_ctrl_chk #(
    parameter int RAW_W  = 4,
    parameter int FP_W   = 8,
    parameter int FREQ_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [RAW_W-1:0]     hist_addr,
    input logic                 hist_we,
    input logic [FP_W:0]        hist_wdata,
    input logic [FP_W:0]        hist_rdata,
    input logic                 freq_start,
    input logic                 freq_done,
    input logic [RAW_W-1:0]     lut_addr,
    input logic                 lut_we,
    input logic [FP_W+FREQ_W:0] lut_wdata,
    input logic                 ready
);
    localparam int TOTAL = 1 << FP_W;

    logic [RAW_W-1:0] last_lut;
    logic             lut_seen;
    logic [FP_W+1:0]  hits;
    logic [1:0]       starts;
    logic [1:0]       dones;

    // Observation counters: increment writes, requests, answers, lookup order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_lut <= '0;
            lut_seen <= 1'b0;
            hits     <= '0;
            starts   <= '0;
            dones    <= '0;
        end else begin
            if (hist_we && hist_wdata != '0) hits <= hits + 1'b1;
            if (freq_start && starts != 2'd3) starts <= starts + 1'b1;
            if (freq_done && dones != 2'd3) dones <= dones + 1'b1;
            if (lut_we) begin
                last_lut <= lut_addr;
                lut_seen <= 1'b1;
            end
        end
    end

    // R2: increment writes back the read value plus one to the same address
    p_rmw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_we && hist_wdata != '0) |->
            (hist_wdata == (FP_W+1)'($past(hist_rdata) + 1'b1)) && (hist_addr == $past(hist_addr, 2)));

    // R4: never more hits than the target, and the first request only at the target
    p_hits_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hits <= (FP_W+2)'(TOTAL));
    p_first_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_start && starts == 2'd0) |-> hits == (FP_W+2)'(TOTAL));

    // R5: single-cycle requests, at most two, and no lookup write before two answers
    p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        freq_start |=> !freq_start);
    p_req_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        freq_start |-> starts < 2'd2);
    p_lut_after_freq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lut_we |-> dones == 2'd2);

    // R6: entries 0 and 1 are zero
    p_low_entries_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lut_we && lut_addr <= RAW_W'(1)) |-> lut_wdata == '0);

    // R7: lookup addresses start at zero and climb by one
    p_lut_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lut_we |-> (lut_seen ? (lut_addr == last_lut + 1'b1) : (lut_addr == '0)));

    // R8: ready is sticky and quiet
    p_ready_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
    p_ready_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!hist_we && !lut_we && !freq_start));
endmodule

bind tdc_cal_ctrl tdc_cal_ctrl_chk #(.RAW_W(RAW_W), .FP_W(FP_W), .FREQ_W(FREQ_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hist_addr  (hist_addr),
    .hist_we    (hist_we),
    .hist_wdata (hist_wdata),
    .hist_rdata (hist_rdata),
    .freq_start (freq_start),
    .freq_done  (freq_done),
    .lut_addr   (lut_addr),
    .lut_we     (lut_we),
    .lut_wdata  (lut_wdata),
    .ready      (ready)
);

// File: tb/tb_tdc_cal_ctrl.sv
// Bench: memory and frequency-counter models, three full calibration runs.
module tb_tdc_cal_ctrl;
    localparam int RAW_W  = 4;
    localparam int FP_W   = 8;
    localparam int FREQ_W = 8;
    localparam int NBINS  = 1 << RAW_W;
    localparam int TOTAL  = 1 << FP_W;
    localparam int HB_W   = FP_W + 1;
    localparam int LUT_W  = FP_W + 1 + FREQ_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pulse_valid = 1'b0;
    logic [RAW_W-1:0]  pulse_raw = '0;
    logic [RAW_W-1:0]  hist_addr;
    logic              hist_we;
    logic [HB_W-1:0]   hist_wdata;
    logic [HB_W-1:0]   hist_rdata = '0;
    logic              freq_start;
    logic              freq_done = 1'b0;
    logic [FREQ_W-1:0] freq_value = '0;
    logic [RAW_W-1:0]  lut_addr;
    logic              lut_we;
    logic [LUT_W-1:0]  lut_wdata;
    logic              ready;

    tdc_cal_ctrl #(.RAW_W(RAW_W), .FP_W(FP_W), .FREQ_W(FREQ_W)) dut (
        .clk(clk), .rst_n(rst_n), .pulse_valid(pulse_valid), .pulse_raw(pulse_raw),
        .hist_addr(hist_addr), .hist_we(hist_we), .hist_wdata(hist_wdata),
        .hist_rdata(hist_rdata), .freq_start(freq_start), .freq_done(freq_done),
        .freq_value(freq_value), .lut_addr(lut_addr), .lut_we(lut_we),
        .lut_wdata(lut_wdata), .ready(ready)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [HB_W-1:0]  hmem [NBINS];
    logic [LUT_W-1:0] lmem [NBINS];
    int lwr [NBINS];
    int lw_total, next_lut, order_err;
    int cnt [NBINS];
    int good_sent, good_at_start;
    int starts_seen, pend, wcyc, rcyc, early_ready;
    bit rseen;
    int fdelay = 3;
    logic [FREQ_W-1:0] f0v = 8'd1, fv = 8'd2;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Memory models: histogram with one-cycle read, lookup write log.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int b = 0; b < NBINS; b++) begin
                hmem[b] <= HB_W'(9'h0A5 + b);
                lmem[b] <= '0;
                lwr[b]  <= 0;
            end
            lw_total  <= 0;
            next_lut  <= 0;
            order_err <= 0;
        end else begin
            if (hist_we) hmem[hist_addr] <= hist_wdata;
            if (lut_we) begin
                lmem[lut_addr] <= lut_wdata;
                lwr[lut_addr]  <= lwr[lut_addr] + 1;
                lw_total       <= lw_total + 1;
                next_lut       <= next_lut + 1;
                if (int'(lut_addr) != next_lut) order_err <= order_err + 1;
            end
        end
        hist_rdata <= hmem[hist_addr];
    end

    // Frequency counter model and ready/write timing monitor, off the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            freq_done   = 1'b0;
            pend        = 0;
            starts_seen = 0;
            rseen       = 1'b0;
            early_ready = 0;
            wcyc        = -1;
            rcyc        = -1;
            good_at_start = -1;
        end else begin
            if (freq_done) freq_done = 1'b0;
            if (freq_start) begin
                starts_seen++;
                if (starts_seen == 1) good_at_start = good_sent;
                pend = fdelay;
            end else if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    freq_done  = 1'b1;
                    freq_value = (starts_seen == 1) ? f0v : fv;
                end
            end
            if (lut_we) wcyc = cyc;
            if (ready && !rseen) begin
                rseen = 1'b1;
                rcyc  = cyc;
            end
            if (ready && lw_total < NBINS) early_ready++;
        end
    end

    function automatic int raw_of(input int sc, input int k);
        if (sc == 0) return k % NBINS;
        if (sc == 1) return 1 + ((k * k + 3 * k) % (NBINS - 1));
        return (k * 5 + k / 16) % NBINS;
    endfunction

    task automatic run(input int sc);
        int bad;
        int w;
        longint acc;
        longint exp;
        rst_n = 1'b0;
        pulse_valid = 1'b0;
        good_sent = 0;
        for (int b = 0; b < NBINS; b++) cnt[b] = 0;
        repeat (3) @(negedge clk);
        check(ready == 1'b0 && lut_we == 1'b0 && freq_start == 1'b0, "reset", ready, 0);
        rst_n = 1'b1;
        // R1: ascending zero writes during the clear phase
        bad = 0;
        for (int c = 0; c < NBINS; c++) begin
            if (c > 0) @(negedge clk);
            if (!(hist_we && int'(hist_addr) == c && hist_wdata == '0)) bad++;
        end
        check(bad == 0, "R1 clear sweep", bad, 0);
        @(negedge clk);
        // R2/R3: good pulses spaced four cycles, junk pulses in the busy window
        for (int k = 0; k < TOTAL; k++) begin
            pulse_valid = 1'b1;
            pulse_raw   = RAW_W'(raw_of(sc, k));
            cnt[raw_of(sc, k)]++;
            good_sent++;
            @(negedge clk);
            pulse_valid = (sc == 1);
            pulse_raw   = '0;
            @(negedge clk);
            @(negedge clk);
            pulse_valid = 1'b0;
            @(negedge clk);
        end
        if (sc == 1) begin
            pulse_valid = 1'b1;
            pulse_raw   = '0;
            repeat (12) @(negedge clk);
            pulse_valid = 1'b0;
        end
        w = 0;
        while (!ready && w < 20000) begin
            @(negedge clk);
            w++;
        end
        check(ready == 1'b1, "R8 ready reached", ready, 1);
        repeat (4) @(negedge clk);
        check(ready == 1'b1, "R8 ready held", ready, 1);
        check(rcyc == wcyc + 1, "R8 ready one cycle after last write", rcyc - wcyc, 1);
        check(early_ready == 0, "R8 no early ready", early_ready, 0);
        check(good_at_start == TOTAL, "R4 hits before first request", good_at_start, TOTAL);
        check(starts_seen == 2, "R5 request count", starts_seen, 2);
        check(order_err == 0 && lw_total == NBINS, "R7 write order", lw_total, NBINS);
        for (int b = 0; b < NBINS; b++) begin
            check(int'(hmem[b]) == cnt[b], (sc == 1 && b == 0) ? "R3 ignored pulses" : "R2 bin count",
                  hmem[b], cnt[b]);
            check(lwr[b] == 1, "R7 single write", lwr[b], 1);
        end
        acc = 0;
        for (int i = 0; i < NBINS; i++) begin
            exp = (longint'(f0v) * acc) / longint'(fv);
            check(longint'(lmem[i]) == exp, "R6 entry value", lmem[i], exp);
            if (sc == 0 && i >= 1)
                check(longint'(lmem[i]) == longint'((i - 1) * (TOTAL / NBINS) / 2),
                      "R9 uniform halving", lmem[i], (i - 1) * (TOTAL / NBINS) / 2);
            if (i >= 1) acc += cnt[i];
        end
    endtask

    bit finished = 1'b0;

    initial begin
        fdelay = 3;  f0v = 8'd1;   fv = 8'd2;  run(0);
        fdelay = 60; f0v = 8'd5;   fv = 8'd3;  run(1);
        fdelay = 1;  f0v = 8'd200; fv = 8'd7;  run(2);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule